// File: doc/BRIEF.md
# Binary64 Multiply Finishing Stage

This block completes a double-precision multiply. An upstream significand multiplier delivers a normalized 53-bit product significand, a biased product exponent, and guard and sticky bits. This stage takes those together with the two raw operands. It settles special operands, applies the result sign and the selected rounding, and resolves overflow and underflow. Underflow is handled either by gradual denormalization or, when the matching trap is enabled, by returning a result whose exponent has been wrapped by a fixed adjust amount.

The stage holds one register. A result, its trap indication and its new flags appear on the cycle after `valid_i`. Status flags accumulate until `clear_i` is asserted. Flag and trap-enable vectors share one bit order: bit 3 invalid, bit 2 overflow, bit 1 underflow, bit 0 inexact.

Top module: `fpm_mul_finish`

## Requirements
- R1: The sign of every finite, zero and infinite result is the XOR of the two operand sign bits.
- R2: Infinity times zero, in either operand order, returns 0x7FF8000000000000 and raises invalid (flag bit 3). With trap-enable bit 3 set, the stage instead asserts `trap_o` with cause bit 3, leaves `result_o` unchanged and raises no flag.
- R3: NaN operands are handled in this order. A signaling operand 1 is returned quieted (fraction bit 51 set) and raises invalid. Otherwise, a NaN operand 1 with a signaling operand 2 returns operand 2 quieted and raises invalid. Otherwise the first NaN found, operand 1 before operand 2, is returned, quieted, raising invalid only if it was signaling.
- R4: Infinity times a finite nonzero value returns a signed infinity, and zero times a finite value returns a signed zero, with no flags in either case.
- R5: `rnd_mode_i` encodes 0 as nearest-even, 1 as toward zero, 2 as toward +infinity and 3 as toward −infinity. An inexact result is incremented by one ULP in these cases: in mode 2 only when positive; in mode 3 only when negative; in mode 0 when guard is set and either sticky or the LSB is set. Mode 1 truncates.
- R6: When rounding carries past the hidden bit, the exponent increases by one and the fraction becomes zero.
- R7: A rounded exponent of 2047 or more without the overflow trap sets overflow and inexact. The result is infinity in mode 0, in mode 2 for positive results and in mode 3 for negative results; otherwise it is the largest finite value with the result sign.
- R8: Overflow with trap-enable bit 2 returns the rounded significand with exponent (e − 1536) mod 2048 and asserts `trap_o` with cause bit 2.
- R9: A rounded exponent of 0 or less with trap-enable bit 1 returns the rounded significand with exponent (e + 1536) mod 2048 and asserts `trap_o` with cause bit 1.
- R10: Non-trapping underflow shifts the unrounded significand right by 1 − e positions. It folds the bits shifted out into guard and sticky and then rounds once. Underflow is raised only when the result is both tiny and inexact, so an exact denormal raises nothing.
- R11: Tininess is judged after rounding. With a product exponent of exactly 0 and an inexact product, the result is not tiny if rounding at normal precision would carry into the normal range.
- R12: An inexact result sets the inexact flag. With trap-enable bit 0 set, it adds cause bit 0 to the trap instead.
- R13: After reset all outputs are zero. Flags are sticky until `clear_i`, which clears them before the same cycle's new flags are merged. `result_o` changes only on `valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs carry an operation this cycle |
| clear_i | input | 1 | Clears the sticky flags |
| op_a_i | input | 64 | Raw operand 1 |
| op_b_i | input | 64 | Raw operand 2 |
| prod_sig_i | input | 53 | Product significand, hidden bit at bit 52 |
| prod_exp_i | input | 13 | Biased product exponent, two's complement |
| prod_guard_i | input | 1 | Guard bit below the product LSB |
| prod_sticky_i | input | 1 | OR of all lower product bits |
| rnd_mode_i | input | 2 | Rounding mode |
| trap_en_i | input | 4 | Trap enables {invalid, overflow, underflow, inexact} |
| result_o | output | 64 | Packed result |
| flags_o | output | 4 | Sticky flags {invalid, overflow, underflow, inexact} |
| trap_o | output | 1 | A trap was taken on the last operation |
| trap_cause_o | output | 4 | Trap causes, same bit order as the flags |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction and a wrap adjust of 1536. This makes both wrapped exponents (514 and 1526) and the overflow boundary at 2047 directly reachable. It also makes the 54-position denormal shift limit reachable from a product exponent of −200. At these widths, the exponent-zero tininess decision can be driven from both sides with an all-ones significand.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_UP   = 2'd2,
    RND_DOWN = 2'd3
  } rnd_mode_e;

  localparam int FLG_W  = 4;
  localparam int FLG_IX = 0;
  localparam int FLG_UF = 1;
  localparam int FLG_OF = 2;
  localparam int FLG_NV = 3;
endpackage

// File: rtl/fpm_rnd_inc.sv
module fpm_rnd_inc
  import fpm_pkg::*;
(
  input  rnd_mode_e mode_i,
  input  logic      neg_i,
  input  logic      lsb_i,
  input  logic      guard_i,
  input  logic      sticky_i,
  output logic      inc_o
);
  always_comb begin
    unique case (mode_i)
      RND_NEAR: inc_o = guard_i & (sticky_i | lsb_i);
      RND_ZERO: inc_o = 1'b0;
      RND_UP:   inc_o = ~neg_i & (guard_i | sticky_i);
      RND_DOWN: inc_o = neg_i & (guard_i | sticky_i);
      default:  inc_o = 1'b0;
    endcase
    // R5: an exact value is never bumped
    if (!(guard_i | sticky_i))
      assert_exact_no_inc_R5: assert (!inc_o);
  end
endmodule

// File: rtl/fpm_denorm.sv
module fpm_denorm #(
  parameter int SIG_W = 53,
  parameter int SH_W  = 6
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             guard_o,
  output logic             sticky_o
);
  localparam int VW = SIG_W + 1;

  logic [VW-1:0]   v;
  logic [2*VW-1:0] full;

  assign v        = {sig_i, guard_i};
  assign full     = {v, {VW{1'b0}}} >> shamt_i;
  assign sig_o    = full[2*VW-1:VW+1];
  assign guard_o  = full[VW];
  assign sticky_o = (|full[VW-1:0]) | sticky_i;
endmodule

// File: rtl/fpm_special.sv
module fpm_special #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  output logic                  special_o,
  output logic                  invalid_o,
  output logic [EXP_W+FRAC_W:0] res_o
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QBIT  = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] QNAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_emax, b_emax, a_fz, b_fz;
  logic a_inf, b_inf, a_nan, b_nan, a_snan, b_snan, a_zero, b_zero, sgn;

  assign a_emax = &a_i[W-2 -: EXP_W];
  assign b_emax = &b_i[W-2 -: EXP_W];
  assign a_fz   = a_i[FRAC_W-1:0] == '0;
  assign b_fz   = b_i[FRAC_W-1:0] == '0;
  assign a_inf  = a_emax & a_fz;
  assign b_inf  = b_emax & b_fz;
  assign a_nan  = a_emax & ~a_fz;
  assign b_nan  = b_emax & ~b_fz;
  assign a_snan = a_nan & ~a_i[FRAC_W-1];
  assign b_snan = b_nan & ~b_i[FRAC_W-1];
  assign a_zero = a_i[W-2:0] == '0;
  assign b_zero = b_i[W-2:0] == '0;
  assign sgn    = a_i[W-1] ^ b_i[W-1];

  always_comb begin
    special_o = 1'b1;
    invalid_o = 1'b0;
    res_o     = '0;
    if (a_snan) begin
      res_o = a_i | QBIT;  invalid_o = 1'b1;
    end else if (a_nan) begin
      res_o     = b_snan ? (b_i | QBIT) : a_i;
      invalid_o = b_snan;
    end else if (b_nan) begin
      res_o = b_i | QBIT;  invalid_o = b_snan;
    end else if ((a_inf & b_zero) | (b_inf & a_zero)) begin
      res_o = QNAN;        invalid_o = 1'b1;
    end else if (a_inf | b_inf) begin
      res_o = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (a_zero | b_zero) begin
      res_o = {sgn, {(W-1){1'b0}}};
    end else begin
      special_o = 1'b0;
    end
    // R3: invalid always comes with a NaN result
    if (invalid_o)
      assert_nv_gives_nan_R3: assert ((&res_o[W-2 -: EXP_W]) && res_o[FRAC_W-1]);
  end
endmodule

// File: rtl/fpm_mul_finish.sv
module fpm_mul_finish
  import fpm_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int WRAP_ADJ = 1536
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      clear_i,
  input  logic [EXP_W+FRAC_W:0]     op_a_i,
  input  logic [EXP_W+FRAC_W:0]     op_b_i,
  input  logic [FRAC_W:0]           prod_sig_i,
  input  logic [EXP_W+1:0]          prod_exp_i,
  input  logic                      prod_guard_i,
  input  logic                      prod_sticky_i,
  input  logic [1:0]                rnd_mode_i,
  input  logic [FLG_W-1:0]          trap_en_i,
  output logic [EXP_W+FRAC_W:0]     result_o,
  output logic [FLG_W-1:0]          flags_o,
  output logic                      trap_o,
  output logic [FLG_W-1:0]          trap_cause_o
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int EI_W  = EXP_W + 2;
  localparam int SH_W  = $clog2(SIG_W + 2);
  localparam logic signed [EI_W-1:0] EXP_ALL1 = EI_W'((1 << EXP_W) - 1);
  localparam logic signed [EI_W-1:0] ZERO_S   = '0;
  localparam logic signed [EI_W-1:0] ONE_S    = EI_W'(1);
  localparam logic signed [EI_W-1:0] SH_LIM   = EI_W'(SIG_W + 1);
  localparam logic [EXP_W-1:0]       ADJ      = EXP_W'(WRAP_ADJ);
  localparam logic [EXP_W-1:0]       EMAX_FIN = EXP_W'((1 << EXP_W) - 2);

  rnd_mode_e mode;
  logic sgn, inexact0;
  logic sp_hit, sp_inv;
  logic [W-1:0] sp_res;

  assign mode     = rnd_mode_e'(rnd_mode_i);
  assign sgn      = op_a_i[W-1] ^ op_b_i[W-1];
  assign inexact0 = prod_guard_i | prod_sticky_i;

  fpm_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_special (
    .a_i(op_a_i), .b_i(op_b_i),
    .special_o(sp_hit), .invalid_o(sp_inv), .res_o(sp_res)
  );

  // Normal-precision rounding
  logic signed [EI_W-1:0] exp_in, exp_n, sh_full;
  logic inc_n, do_rnd, carry_n, hid_n;
  logic [FRAC_W-1:0] frac_n;

  assign exp_in = $signed(prod_exp_i);

  fpm_rnd_inc u_rnd_norm (
    .mode_i(mode), .neg_i(sgn), .lsb_i(prod_sig_i[0]),
    .guard_i(prod_guard_i), .sticky_i(prod_sticky_i), .inc_o(inc_n)
  );

  assign do_rnd = inexact0 & ((exp_in > ZERO_S) | trap_en_i[FLG_UF]);
  assign {carry_n, hid_n, frac_n} = {1'b0, prod_sig_i} + {{SIG_W{1'b0}}, do_rnd & inc_n};
  assign exp_n  = exp_in + $signed({{(EI_W-1){1'b0}}, carry_n});

  logic ovf, unf, tiny, to_inf;
  logic [EXP_W-1:0] ov_exp, uf_exp;

  assign ovf    = exp_n >= EXP_ALL1;
  assign unf    = exp_n <= ZERO_S;
  assign ov_exp = exp_n[EXP_W-1:0] - ADJ;
  assign uf_exp = exp_n[EXP_W-1:0] + ADJ;
  // R11: tiny unless a normal-precision round would reach the normal range
  assign tiny   = !((exp_in == ZERO_S) & inexact0 & inc_n & (&prod_sig_i));
  assign to_inf = (mode == RND_NEAR) | ((mode == RND_UP) & ~sgn) | ((mode == RND_DOWN) & sgn);

  // Gradual underflow path
  logic [SH_W-1:0]  shamt;
  logic [SIG_W-1:0] d_sig, sum_d;
  logic d_g, d_s, inc_d;

  assign sh_full = ONE_S - exp_n;
  assign shamt   = (sh_full > SH_LIM) ? SH_LIM[SH_W-1:0] : sh_full[SH_W-1:0];

  fpm_denorm #(.SIG_W(SIG_W), .SH_W(SH_W)) u_denorm (
    .sig_i(prod_sig_i), .guard_i(prod_guard_i), .sticky_i(prod_sticky_i),
    .shamt_i(shamt), .sig_o(d_sig), .guard_o(d_g), .sticky_o(d_s)
  );

  fpm_rnd_inc u_rnd_den (
    .mode_i(mode), .neg_i(sgn), .lsb_i(d_sig[0]),
    .guard_i(d_g), .sticky_i(d_s), .inc_o(inc_d)
  );

  assign sum_d = d_sig + {{(SIG_W-1){1'b0}}, inc_d};

  // Result and exception selection
  logic [W-1:0]     res;
  logic [FLG_W-1:0] raise, cause;
  logic             wr, ix;

  always_comb begin
    res   = '0;
    raise = '0;
    cause = '0;
    wr    = 1'b1;
    ix    = 1'b0;
    if (sp_hit) begin
      res = sp_res;
      if (sp_inv) begin
        if (trap_en_i[FLG_NV]) begin
          cause[FLG_NV] = 1'b1;
          wr            = 1'b0;
        end else begin
          raise[FLG_NV] = 1'b1;
        end
      end
    end else begin
      ix = inexact0;
      if (ovf) begin
        if (trap_en_i[FLG_OF]) begin
          cause[FLG_OF] = 1'b1;
          res = {sgn, ov_exp, frac_n};
        end else begin
          raise[FLG_OF] = 1'b1;
          ix  = 1'b1;
          res = to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                       : {sgn, EMAX_FIN, {FRAC_W{1'b1}}};
        end
      end else if (unf) begin
        if (trap_en_i[FLG_UF]) begin
          cause[FLG_UF] = 1'b1;
          res = {sgn, uf_exp, frac_n};
        end else begin
          ix  = d_g | d_s;
          res = {sgn, {(EXP_W-1){1'b0}}, sum_d};
          raise[FLG_UF] = ix & tiny;
        end
      end else begin
        res = {sgn, exp_n[EXP_W-1:0], frac_n};
      end
      if (ix) begin
        if (trap_en_i[FLG_IX]) cause[FLG_IX] = 1'b1;
        else                   raise[FLG_IX] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o     <= '0;
      flags_o      <= '0;
      trap_o       <= 1'b0;
      trap_cause_o <= '0;
    end else begin
      if (clear_i | valid_i)
        flags_o <= (clear_i ? '0 : flags_o) | (valid_i ? raise : '0);
      trap_o       <= valid_i & (|cause);
      trap_cause_o <= valid_i ? cause : '0;
      if (valid_i & wr) result_o <= res;
    end
  end

  // R13: flags never drop without a clear
  assert_flags_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R13: a lone clear empties the flags
  assert_clear_empties_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !valid_i) |=> (flags_o == '0));

  // R2: trapped invalid leaves the result register alone
  assert_nv_trap_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sp_hit && sp_inv && trap_en_i[FLG_NV]) |=> $stable(result_o));

  // R7: untrapped overflow lands on the top two exponent codes
  assert_ovf_saturates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sp_hit && ovf && !trap_en_i[FLG_OF]) |=> (result_o[W-2 -: EXP_W] >= EMAX_FIN));

  // R10: gradual underflow yields a denormal or the smallest normal
  assert_unf_small_exp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sp_hit && unf && !trap_en_i[FLG_UF]) |=> (result_o[W-2 -: EXP_W] <= EXP_W'(1)));

  // R10: underflow is only raised alongside inexact
  assert_uf_with_ix_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[FLG_UF]) |-> (flags_o[FLG_IX] || trap_cause_o[FLG_IX]));

  // R6: a normalized product stays normalized or carries out
  assert_round_norm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prod_sig_i[FRAC_W]) |-> (hid_n || carry_n));
endmodule

// File: tb/fpm_mul_finish_bench.sv
module fpm_mul_finish_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 35;

  typedef struct packed {
    logic [3:0]  req;
    logic [63:0] a;
    logic [63:0] b;
    logic [52:0] sig;
    logic [12:0] ex;
    logic        g;
    logic        s;
    logic [1:0]  mode;
    logic [3:0]  ten;
    logic [63:0] res;
    logic [3:0]  flg;
    logic [3:0]  cause;
  } vec_t;

  localparam logic [63:0] P1 = 64'h3FF0000000000000;
  localparam logic [63:0] M1 = 64'hBFF0000000000000;
  localparam logic [52:0] S1 = 53'h10000000000000;
  localparam logic [52:0] SF = 53'h1FFFFFFFFFFFFF;

  localparam vec_t VECS [N_VEC] = '{
    '{4'd1,  P1, P1, 53'h10000000000001, 13'd1023, 1'b0, 1'b0, 2'd0, 4'h0, 64'h3FF0000000000001, 4'h0, 4'h0}, // R1
    '{4'd1,  P1, M1, 53'h10000000000001, 13'd1023, 1'b0, 1'b0, 2'd0, 4'h0, 64'hBFF0000000000001, 4'h0, 4'h0}, // R1
    '{4'd5,  P1, P1, 53'h10000000000001, 13'd1023, 1'b1, 1'b0, 2'd0, 4'h0, 64'h3FF0000000000002, 4'h1, 4'h0}, // R5 tie odd
    '{4'd5,  P1, P1, 53'h10000000000002, 13'd1023, 1'b1, 1'b0, 2'd0, 4'h0, 64'h3FF0000000000002, 4'h1, 4'h0}, // R5 tie even
    '{4'd5,  P1, P1, 53'h10000000000001, 13'd1023, 1'b1, 1'b1, 2'd1, 4'h0, 64'h3FF0000000000001, 4'h1, 4'h0}, // R5 toward zero
    '{4'd5,  P1, P1, 53'h10000000000001, 13'd1023, 1'b0, 1'b1, 2'd2, 4'h0, 64'h3FF0000000000002, 4'h1, 4'h0}, // R5 up, pos
    '{4'd5,  P1, M1, 53'h10000000000001, 13'd1023, 1'b0, 1'b1, 2'd2, 4'h0, 64'hBFF0000000000001, 4'h1, 4'h0}, // R5 up, neg
    '{4'd5,  P1, M1, 53'h10000000000001, 13'd1023, 1'b0, 1'b1, 2'd3, 4'h0, 64'hBFF0000000000002, 4'h1, 4'h0}, // R5 down, neg
    '{4'd6,  P1, P1, SF,                 13'd1023, 1'b1, 1'b1, 2'd0, 4'h0, 64'h4000000000000000, 4'h1, 4'h0}, // R6
    '{4'd7,  P1, P1, S1,                 13'd2047, 1'b0, 1'b0, 2'd0, 4'h0, 64'h7FF0000000000000, 4'h5, 4'h0}, // R7
    '{4'd7,  P1, P1, S1,                 13'd2047, 1'b0, 1'b0, 2'd1, 4'h0, 64'h7FEFFFFFFFFFFFFF, 4'h5, 4'h0}, // R7
    '{4'd7,  P1, M1, S1,                 13'd2047, 1'b0, 1'b0, 2'd2, 4'h0, 64'hFFEFFFFFFFFFFFFF, 4'h5, 4'h0}, // R7
    '{4'd7,  P1, M1, S1,                 13'd2047, 1'b0, 1'b0, 2'd3, 4'h0, 64'hFFF0000000000000, 4'h5, 4'h0}, // R7
    '{4'd6,  P1, P1, SF,                 13'd2046, 1'b1, 1'b0, 2'd0, 4'h0, 64'h7FF0000000000000, 4'h5, 4'h0}, // R6 carry to overflow
    '{4'd8,  P1, P1, 53'h10000000000005, 13'd2050, 1'b0, 1'b0, 2'd0, 4'h4, 64'h2020000000000005, 4'h0, 4'h4}, // R8
    '{4'd8,  P1, P1, 53'h10000000000005, 13'd2050, 1'b0, 1'b1, 2'd0, 4'h4, 64'h2020000000000005, 4'h1, 4'h4}, // R8
    '{4'd12, P1, P1, 53'h10000000000005, 13'd2050, 1'b0, 1'b1, 2'd0, 4'h5, 64'h2020000000000005, 4'h0, 4'h5}, // R12
    '{4'd9,  P1, P1, 53'h10000000000003, 13'h1FF6, 1'b0, 1'b0, 2'd0, 4'h2, 64'h5F60000000000003, 4'h0, 4'h2}, // R9
    '{4'd10, P1, P1, 53'h10000000000002, 13'd0,    1'b0, 1'b0, 2'd0, 4'h0, 64'h0008000000000001, 4'h0, 4'h0}, // R10 exact
    '{4'd10, P1, P1, 53'h10000000000003, 13'h1FFF, 1'b0, 1'b0, 2'd0, 4'h0, 64'h0004000000000001, 4'h3, 4'h0}, // R10
    '{4'd11, P1, P1, SF,                 13'd0,    1'b1, 1'b0, 2'd0, 4'h0, 64'h0010000000000000, 4'h1, 4'h0}, // R11 not tiny
    '{4'd11, P1, P1, SF,                 13'd0,    1'b0, 1'b0, 2'd1, 4'h0, 64'h000FFFFFFFFFFFFF, 4'h3, 4'h0}, // R11 tiny
    '{4'd10, P1, P1, S1,                 13'h1F38, 1'b0, 1'b0, 2'd0, 4'h0, 64'h0000000000000000, 4'h3, 4'h0}, // R10 far shift
    '{4'd10, P1, M1, S1,                 13'h1F38, 1'b0, 1'b0, 2'd3, 4'h0, 64'h8000000000000001, 4'h3, 4'h0}, // R10 far shift, down
    '{4'd2,  64'h7FF0000000000000, 64'h0, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h0, 64'h7FF8000000000000, 4'h8, 4'h0}, // R2
    '{4'd2,  64'h0, 64'hFFF0000000000000, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h0, 64'h7FF8000000000000, 4'h8, 4'h0}, // R2
    '{4'd4,  64'h7FF0000000000000, M1, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h0, 64'hFFF0000000000000, 4'h0, 4'h0}, // R4
    '{4'd4,  64'h8000000000000000, P1, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h0, 64'h8000000000000000, 4'h0, 4'h0}, // R4
    '{4'd3,  64'h7FF0000000000001, 64'h7FF8000000000002, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h0, 64'h7FF8000000000001, 4'h8, 4'h0}, // R3
    '{4'd3,  64'h7FF8000000000003, 64'hFFF0000000000004, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h0, 64'hFFF8000000000004, 4'h8, 4'h0}, // R3
    '{4'd3,  64'hFFF8000000000005, 64'h7FF8000000000006, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h0, 64'hFFF8000000000005, 4'h0, 4'h0}, // R3
    '{4'd3,  P1, 64'h7FF0000000000007, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h0, 64'h7FF8000000000007, 4'h8, 4'h0}, // R3
    '{4'd3,  64'h7FF0000000000000, 64'h7FF8000000000009, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h0, 64'h7FF8000000000009, 4'h0, 4'h0}, // R3
    '{4'd12, P1, P1, 53'h10000000000001, 13'd1023, 1'b1, 1'b0, 2'd0, 4'h1, 64'h3FF0000000000002, 4'h0, 4'h1}, // R12
    '{4'd9,  P1, P1, 53'h10000000000003, 13'h1FF6, 1'b1, 1'b1, 2'd0, 4'h2, 64'h5F60000000000004, 4'h1, 4'h2}  // R9 rounded
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic [52:0] prod_sig_i = '0;
  logic [12:0] prod_exp_i = '0;
  logic        prod_guard_i = 1'b0;
  logic        prod_sticky_i = 1'b0;
  logic [1:0]  rnd_mode_i = '0;
  logic [3:0]  trap_en_i = '0;
  logic [63:0] result_o;
  logic [3:0]  flags_o;
  logic        trap_o;
  logic [3:0]  trap_cause_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fpm_mul_finish u_fpm_mul_finish (
    .clk_i, .rst_ni, .valid_i, .clear_i, .op_a_i, .op_b_i, .prod_sig_i,
    .prod_exp_i, .prod_guard_i, .prod_sticky_i, .rnd_mode_i, .trap_en_i,
    .result_o, .flags_o, .trap_o, .trap_cause_o
  );

  task automatic drive(input vec_t v, input logic clr);
    op_a_i = v.a; op_b_i = v.b; prod_sig_i = v.sig; prod_exp_i = v.ex;
    prod_guard_i = v.g; prod_sticky_i = v.s; rnd_mode_i = v.mode;
    trap_en_i = v.ten; valid_i = 1'b1; clear_i = clr;
    @(negedge clk_i);
    valid_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic check(input string tag, input logic [63:0] res, input logic [3:0] flg,
                       input logic trp, input logic [3:0] cause);
    n_chk++;
    if (result_o !== res || flags_o !== flg || trap_o !== trp || trap_cause_o !== cause) begin
      n_err++;
      $display("FAIL %s: got res=%h flags=%h trap=%b cause=%h, want res=%h flags=%h trap=%b cause=%h",
               tag, result_o, flags_o, trap_o, trap_cause_o, res, flg, trp, cause);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R13 reset state", 64'h0, 4'h0, 1'b0, 4'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < N_VEC; i++) begin
      drive(VECS[i], 1'b1);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].res, VECS[i].flg,
            VECS[i].cause != 4'h0, VECS[i].cause);
    end

    // R2: trapped invalid keeps previous result, raises nothing
    drive(VECS[0], 1'b1);
    drive('{4'd2, 64'h7FF0000000000000, 64'h0, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h8,
            64'h0, 4'h0, 4'h0}, 1'b1);
    check("R2 invalid trap holds result", 64'h3FF0000000000001, 4'h0, 1'b1, 4'h8);

    // R3: trapped signaling NaN keeps previous result as well
    drive('{4'd3, 64'h7FF0000000000001, P1, 53'h0, 13'd0, 1'b0, 1'b0, 2'd0, 4'h8,
            64'h0, 4'h0, 4'h0}, 1'b1);
    check("R3 snan trap holds result", 64'h3FF0000000000001, 4'h0, 1'b1, 4'h8);

    // R13: flags accumulate without clear
    drive(VECS[2], 1'b1);
    drive(VECS[19], 1'b0);
    check("R13 sticky accumulate", 64'h0004000000000001, 4'h3, 1'b0, 4'h0);
    drive(VECS[0], 1'b0);
    check("R13 exact op keeps flags", 64'h3FF0000000000001, 4'h3, 1'b0, 4'h0);
    drive(VECS[24], 1'b0);
    check("R13 invalid joins flags", 64'h7FF8000000000000, 4'hB, 1'b0, 4'h0);

    // R13: clear alone empties flags, result held while idle
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    check("R13 clear", 64'h7FF8000000000000, 4'h0, 1'b0, 4'h0);
    op_a_i = P1; op_b_i = M1; prod_sig_i = S1; prod_exp_i = 13'd2047;
    @(negedge clk_i);
    check("R13 no valid no change", 64'h7FF8000000000000, 4'h0, 1'b0, 4'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule